// File: doc/BRIEF.md
# Marching-Dash Wire Animator

This block decides, pixel by pixel, whether the beam sits on a lit dash of an animated L-shaped wire in an inverter diagram. Each beat it takes a screen coordinate, an animation phase, a per-wire mask and the logic level being shown. It returns a draw flag and a 3-bit palette code. The position on a bent wire becomes one path length. The first leg runs down the screen and the count carries on along the second leg, which runs across. Moving dashes come from one bit of that length minus the phase, so no pattern is stored anywhere.

Two wires are modelled, the pull-up path and the pull-down path. The logic level picks which one animates. Beats travel as a valid/ready stream. The result of an accepted beat comes out on the next cycle through one register stage. The input may be stalled by the output: `in_ready` is high when the output register is empty or is being drained in the same cycle. An output beat holds still while `out_valid` is high and `out_ready` is low.

Top module: `dash_path_anim`

## Requirements
- R1: For the pull-up wire, when `in_py` < 220 the path length is `in_py` - 80.
- R2: For the pull-up wire, when `in_py` >= 220 the path length is 140 + `in_px` - 200, continuing the count along the horizontal leg.
- R3: A pixel on the selected wire is lit when bit 4 of (path length - `in_phase`) is 1. This gives runs of 16 lit and 16 dark positions.
- R4: Raising `in_phase` by one makes a given lit/dark value appear one position further along the wire, so the dashes travel.
- R5: When `in_level` is 0, only the pull-up wire (mask bit 0) can draw, with colour code 4 (yellow). Mask bit 1 has no effect.
- R6: When `in_level` is 1, only the pull-down wire (mask bit 1) can draw, with colour code 2 (green). This wire's vertical leg starts at y 260 and bends at y 400. Its horizontal leg starts at x 200. Mask bit 0 has no effect.
- R7: `out_draw` is 1 only when the selected mask bit is 1 and the dash is lit. Otherwise `out_draw` is 0 and `out_color` is 0.
- R8: All path arithmetic wraps modulo 2^11, including coordinates below the leg offsets.
- R9: `in_ready` equals (not `out_valid`) or `out_ready`. An accepted beat appears on the output on the next cycle. A stalled output keeps `out_valid`, `out_draw` and `out_color` unchanged.
- R10: While `rst_n` is low, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| in_valid | input | 1 | input beat valid |
| in_ready | output | 1 | block can accept a beat |
| in_px | input | 11 | beam x coordinate |
| in_py | input | 11 | beam y coordinate |
| in_phase | input | 8 | animation phase, low bits of a frame count |
| in_mask | input | 2 | bit 0: pixel inside pull-up wire; bit 1: pixel inside pull-down wire |
| in_level | input | 1 | logic level shown by the diagram |
| out_valid | output | 1 | output beat valid |
| out_ready | input | 1 | downstream accepts the beat |
| out_draw | output | 1 | pixel is a lit dash |
| out_color | output | 3 | palette code: 0 none, 2 green, 4 yellow |

## Verification
A wrong leg offset or bend comparison shows up as dashes shifted along one leg of the wire. This appears on the first beat whose coordinate falls on that leg. A wrong path selection or a mask leak shows up as a draw on a wire that should be dark, in the beat right after acceptance. A fault in the output register appears at the ports within one cycle: a lost beat, a duplicated beat, or an output that changes during a stall.

// File: rtl/dash_anim_pkg.sv
package dash_anim_pkg;
  localparam int NUM_PATHS = 2;
  localparam int PATH_UP   = 0;
  localparam int PATH_DOWN = 1;

  // Per-path geometry: vertical leg start, bend row, horizontal leg start column
  localparam int PATH_Y0   [NUM_PATHS] = '{80, 260};
  localparam int PATH_BEND [NUM_PATHS] = '{220, 400};
  localparam int PATH_X0   [NUM_PATHS] = '{200, 200};

  typedef enum logic [2:0] {
    COL_NONE   = 3'd0,
    COL_GREEN  = 3'd2,
    COL_YELLOW = 3'd4
  } color_e;

  typedef struct packed {
    logic   draw;
    color_e color;
  } pix_res_t;
endpackage

// File: rtl/wire_path_len.sv
module wire_path_len #(
  parameter int COORD_W = 11,
  parameter int Y0      = 80,
  parameter int BEND    = 220,
  parameter int X0      = 200
) (
  input  logic [COORD_W-1:0] px,
  input  logic [COORD_W-1:0] py,
  output logic [COORD_W-1:0] len
);
  localparam logic [COORD_W-1:0] Y0_V   = COORD_W'(Y0);
  localparam logic [COORD_W-1:0] BEND_V = COORD_W'(BEND);
  localparam logic [COORD_W-1:0] X0_V   = COORD_W'(X0);
  localparam logic [COORD_W-1:0] LEG1_V = COORD_W'(BEND - Y0);

  always_comb begin
    if (py < BEND_V) len = py - Y0_V;
    else             len = LEG1_V + px - X0_V;
  end
endmodule

// File: rtl/dash_phase_test.sv
module dash_phase_test #(
  parameter int COORD_W  = 11,
  parameter int PHASE_W  = 8,
  parameter int DASH_BIT = 4
) (
  input  logic [COORD_W-1:0] len,
  input  logic [PHASE_W-1:0] phase,
  output logic               lit
);
  logic [COORD_W-1:0] shifted;
  always_comb begin
    shifted = len - COORD_W'(phase);
    lit     = shifted[DASH_BIT];
  end
endmodule

// File: rtl/pix_stream_reg.sv
module pix_stream_reg
  import dash_anim_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  output logic     in_ready,
  input  pix_res_t in_res,
  output logic     out_valid,
  input  logic     out_ready,
  output pix_res_t out_res
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '{draw: 1'b0, color: COL_NONE};
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_res <= in_res;
    end
  end
endmodule

// File: rtl/dash_path_anim.sv
module dash_path_anim
  import dash_anim_pkg::*;
#(
  parameter int COORD_W  = 11,
  parameter int PHASE_W  = 8,
  parameter int DASH_BIT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [COORD_W-1:0] in_px,
  input  logic [COORD_W-1:0] in_py,
  input  logic [PHASE_W-1:0] in_phase,
  input  logic [1:0]         in_mask,
  input  logic               in_level,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_draw,
  output logic [2:0]         out_color
);
  logic [NUM_PATHS-1:0] path_lit;

  for (genvar g = 0; g < NUM_PATHS; g++) begin : g_path
    logic [COORD_W-1:0] len;
    wire_path_len #(
      .COORD_W(COORD_W), .Y0(PATH_Y0[g]), .BEND(PATH_BEND[g]), .X0(PATH_X0[g])
    ) u_len (
      .px(in_px), .py(in_py), .len(len)
    );
    dash_phase_test #(
      .COORD_W(COORD_W), .PHASE_W(PHASE_W), .DASH_BIT(DASH_BIT)
    ) u_dash (
      .len(len), .phase(in_phase), .lit(path_lit[g])
    );
  end

  // Level picks the conducting path: low -> pull-up, high -> pull-down
  pix_res_t cur_res;
  always_comb begin
    cur_res = '{draw: 1'b0, color: COL_NONE};
    if (!in_level) begin
      if (in_mask[PATH_UP] && path_lit[PATH_UP])
        cur_res = '{draw: 1'b1, color: COL_YELLOW};
    end else begin
      if (in_mask[PATH_DOWN] && path_lit[PATH_DOWN])
        cur_res = '{draw: 1'b1, color: COL_GREEN};
    end
  end

  pix_res_t out_res;
  pix_stream_reg u_oreg (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_res(cur_res),
    .out_valid(out_valid), .out_ready(out_ready), .out_res(out_res)
  );

  assign out_draw  = out_res.draw;
  assign out_color = out_res.color;
endmodule

// File: rtl/dash_path_anim_chk.sv
module dash_path_anim_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [1:0] in_mask,
  input logic       in_level,
  input logic       out_valid,
  input logic       out_ready,
  input logic       out_draw,
  input logic [2:0] out_color
);
  a_r10_reset_empty: assert property (@(posedge clk) !rst_n |=> !out_valid);

  a_r9_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_draw) && $stable(out_color)));

  a_r7_dark_no_color: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_draw) |-> (out_color == 3'd0));

  a_r7_mask_gates: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mask == 2'b00) |=> !out_draw);

  a_r5_low_yellow_only: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_level) |=> (out_color != 3'd2));

  a_r6_high_green_only: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_level) |=> (out_color != 3'd4));
endmodule

bind dash_path_anim dash_path_anim_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_mask(in_mask), .in_level(in_level), .out_valid(out_valid),
  .out_ready(out_ready), .out_draw(out_draw), .out_color(out_color)
);

// File: tb/dash_path_anim_bench.sv
module dash_path_anim_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        in_valid = 0, in_level = 0, out_ready = 0;
  logic [10:0] in_px = 0, in_py = 0;
  logic [7:0]  in_phase = 0;
  logic [1:0]  in_mask = 0;
  logic        in_ready, out_valid, out_draw;
  logic [2:0]  out_color;

  dash_path_anim u_dash_path_anim (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_px(in_px), .in_py(in_py), .in_phase(in_phase), .in_mask(in_mask),
    .in_level(in_level), .out_valid(out_valid), .out_ready(out_ready),
    .out_draw(out_draw), .out_color(out_color)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // Reference state
  bit    m_valid = 0, m_draw = 0;
  int    m_color = 0;
  string m_tag = "R10";

  function automatic int path_len(int px, int py, int y0, int bend, int x0);
    if (py < bend) return (py - y0) & 2047;
    return ((bend - y0) + (px - x0)) & 2047;
  endfunction

  function automatic bit dash_on(int len, int ph);
    int d;
    d = (len - ph) & 2047;
    return (d / 16) % 2 == 1;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Model update for the edge that just passed, using inputs held across it
  task automatic model_step();
    bit rdy;
    int y0, bend, x0, len;
    bit on_wire;
    rdy = !m_valid || out_ready;
    if (rdy) begin
      m_valid = in_valid;
      if (in_valid) begin
        if (!in_level) begin y0 = 80;  bend = 220; x0 = 200; on_wire = in_mask[0]; end
        else           begin y0 = 260; bend = 400; x0 = 200; on_wire = in_mask[1]; end
        len = path_len(in_px, in_py, y0, bend, x0);
        m_draw  = on_wire && dash_on(len, in_phase);
        m_color = m_draw ? (in_level ? 2 : 4) : 0;
        if (!on_wire)                       m_tag = "R7";
        else if (in_py < y0)                m_tag = "R8";
        else if (in_level)                  m_tag = "R6";
        else if (in_py < bend)              m_tag = "R1_R3";
        else                                m_tag = "R2_R3";
      end
    end else m_tag = "R9";
  endtask

  task automatic compare();
    chk(in_ready == (!m_valid || out_ready), "R9", "in_ready", in_ready, !m_valid || out_ready);
    chk(out_valid == m_valid, "R9", "out_valid", out_valid, m_valid);
    if (m_valid) begin
      chk(out_draw == m_draw, m_tag, "out_draw", out_draw, m_draw);
      chk(out_color == m_color[2:0], m_tag, "out_color", out_color, m_color);
    end
  endtask

  task automatic beat(int px, int py, int ph, int mask, bit lvl, bit ordy);
    in_valid = 1; in_px = px[10:0]; in_py = py[10:0]; in_phase = ph[7:0];
    in_mask = mask[1:0]; in_level = lvl; out_ready = ordy;
    @(negedge clk);
    model_step();
    compare();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R10", "out_valid in reset", out_valid, 0);
    rst_n = 1;
    @(negedge clk);
    compare();
    // R1: vertical leg, dark at len 0, lit at len 16, dark at 139
    beat(300, 80, 0, 1, 0, 1);
    beat(300, 96, 0, 1, 0, 1);
    beat(300, 219, 0, 1, 0, 1);
    // R2: horizontal leg, len 140 dark, len 144 lit
    beat(200, 220, 0, 1, 0, 1);
    beat(204, 220, 0, 1, 0, 1);
    // R4: phase step moves pattern: len 16 ph 0 lit; len 17 ph 1 lit; len 16 ph 1 dark
    beat(0, 97, 1, 1, 0, 1);
    beat(0, 96, 1, 1, 0, 1);
    // R8: wrap below offset
    beat(0, 10, 0, 1, 0, 1);
    beat(100, 300, 200, 1, 0, 1);
    // R5: low level, pull-down mask only -> dark
    beat(0, 96, 0, 2, 0, 1);
    // R6: high level, pull-down wire lit / pull-up mask only -> dark
    beat(0, 276, 0, 2, 1, 1);
    beat(0, 276, 0, 1, 1, 1);
    beat(220, 400, 0, 3, 1, 1);
    // R7: mask off
    beat(0, 96, 0, 0, 0, 1);
    // R9: stall then drain
    beat(0, 96, 0, 1, 0, 0);
    beat(0, 80, 0, 1, 0, 0);
    beat(0, 80, 0, 1, 0, 0);
    beat(0, 80, 0, 1, 0, 1);
    // Random stream with random gaps and back-pressure
    for (int i = 0; i < 4000; i++) begin
      in_valid = ($urandom % 4) != 0;
      in_px = 11'($urandom); in_py = 11'($urandom % 600);
      in_phase = 8'($urandom); in_mask = 2'($urandom);
      in_level = 1'($urandom); out_ready = ($urandom % 3) != 0;
      @(negedge clk);
      model_step();
      compare();
    end
    done = 1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule